// File: doc/BRIEF.md
# Packet FEC Configuration and Statistics Register Bank

This block is the software-facing register bank of a layer-2 forward-error-correction engine. The engine splits each frame into four coded packets and rebuilds the frame when enough of them arrive. A Wishbone master uses the bank to switch the encoder and the decoder on or off, to choose the code type, and to program two Ethertype values. The first Ethertype marks encoded frames. The second marks ordinary payload traffic. These settings drive the datapath directly through dedicated output ports.

The datapath reports five kinds of event as single-cycle pulses:
- a frame was encoded,
- a frame was decoded,
- an oversize (jumbo) frame was seen on receive,
- a frame could not be rebuilt because more than two of its four coded packets were lost,
- an encode error occurred.

Each event has its own saturating counter. Software reads the counters and cannot write them. Every bus access completes with a fixed one-cycle acknowledge.

Top module: `fec_csr`

## Requirements
- R1: After reset, `enc_en` and `dec_en` are 0 and `code_type` is 0. `fec_ethtype` is 0xBABE, `pay_ethtype` is 0x0800, and every counter reads 0.
- R2: Word offset 0x00 holds the enable field. Bit 0 drives `enc_en` and bit 1 drives `dec_en`, so 0 turns both off, 1 enables only the encoder, 2 only the decoder and 3 both. A read returns those two bits and zeros above them.
- R3: Offset 0x04 holds the code type: the low CODE_W bits of the write data, read back zero-extended and driven on `code_type`.
- R4: Offset 0x08 holds the encoded-frame Ethertype and offset 0x0C the payload Ethertype. Each keeps the low 16 bits of the write data and ignores the upper 16. Each reads back zero-extended and appears on `fec_ethtype` or `pay_ethtype`.
- R5: When `wb_cyc` and `wb_stb` are high and `wb_ack` is low, `wb_ack` rises in the following cycle for exactly one cycle. Read data is valid in that cycle and reads 0 whenever `wb_ack` is low.
- R6: The counters are mapped to the event pulse bits as follows:

  | Event pulse bit | Event | Counter offset |
  |---|---|---|
  | 0 | encoded | 0x10 |
  | 1 | decoded | 0x14 |
  | 2 | receive jumbo | 0x18 |
  | 3 | decode failure | 0x1C |
  | 4 | encode error | 0x20 |

  Counters read back zero-extended.
- R7: A counter rises by exactly one for each clock cycle in which its pulse bit is high. Any combination of bits pulsed in the same cycle updates each counter on its own.
- R8: A counter stops at its all-ones value (CNT_W bits, 32 by default) and never wraps.
- R9: A write to a counter offset leaves that counter unchanged.
- R10: A read of any word offset above 0x20 returns 0. A write to such an offset changes no register.
- R11: The configuration outputs change only in the cycle after an acknowledged write. Event pulses never alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_cyc | input | 1 | Bus cycle |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Write enable |
| wb_adr | input | ADDR_W | Byte address; bits [1:0] ignored |
| wb_dat_w | input | 32 | Write data |
| wb_ack | output | 1 | One-cycle acknowledge |
| wb_dat_r | output | 32 | Read data |
| evt_pulse | input | 5 | Event pulses: bit 0 encoded, 1 decoded, 2 receive jumbo, 3 decode failure, 4 encode error |
| enc_en | output | 1 | Encoder enable |
| dec_en | output | 1 | Decoder enable |
| code_type | output | CODE_W | Code type selector |
| fec_ethtype | output | 16 | Ethertype of encoded frames |
| pay_ethtype | output | 16 | Ethertype of payload frames |

## Verification
The bench targets the saturation corner, the independence of counters pulsed together, and the bus acknowledge timing:
- The bench drives the decode-failure pulse well past the counter limit. A counter that wrapped would read back a small number instead of all-ones.
- Random multi-bit pulse patterns held on consecutive cycles expose two faults. A shared or mis-indexed increment would credit the wrong offset. A counter that missed back-to-back pulses would lag the bench model.
- Writes to counter and unmapped offsets, and writes with stray upper data bits, catch three decode faults. A write that leaks into a counter would change its value. A missing address check would alias the unmapped space onto real registers. A register that stored too many bits would read back the stray bits.
- A late, doubled or missing acknowledge would show up in the per-access checks on `wb_ack`.

// File: rtl/fec_csr_pkg.sv
package fec_csr_pkg;
    // Word indices (byte offset / 4); counter order follows evt_pulse bits
    localparam int IDX_ENABLE   = 0;
    localparam int IDX_CODE     = 1;
    localparam int IDX_FEC_ET   = 2;
    localparam int IDX_PAY_ET   = 3;
    localparam int IDX_CNT_BASE = 4;
    localparam int NUM_EVT      = 5;
    localparam int IDX_LAST     = IDX_CNT_BASE + NUM_EVT - 1;

    localparam logic [15:0] FEC_ET_RST = 16'hBABE;
    localparam logic [15:0] PAY_ET_RST = 16'h0800;

    typedef struct packed {
        logic        ack;
        logic [31:0] rdata;
    } bus_state_t;
endpackage

// File: rtl/fec_cfg_regs.sv
module fec_cfg_regs
    import fec_csr_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_enable,
    input  logic              wr_code,
    input  logic              wr_fec_et,
    input  logic              wr_pay_et,
    input  logic [15:0]       wr_data,
    output logic              enc_en,
    output logic              dec_en,
    output logic [CODE_W-1:0] code_type,
    output logic [15:0]       fec_ethtype,
    output logic [15:0]       pay_ethtype
);
    typedef struct packed {
        logic              enc;
        logic              dec;
        logic [CODE_W-1:0] code;
        logic [15:0]       fec_et;
        logic [15:0]       pay_et;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_enable) begin
            cfg_d.enc = wr_data[0];
            cfg_d.dec = wr_data[1];
        end
        if (wr_code)   cfg_d.code   = wr_data[CODE_W-1:0];
        if (wr_fec_et) cfg_d.fec_et = wr_data;
        if (wr_pay_et) cfg_d.pay_et = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{enc: 1'b0, dec: 1'b0, code: '0,
                       fec_et: FEC_ET_RST, pay_et: PAY_ET_RST};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign enc_en      = cfg_q.enc;
    assign dec_en      = cfg_q.dec;
    assign code_type   = cfg_q.code;
    assign fec_ethtype = cfg_q.fec_et;
    assign pay_ethtype = cfg_q.pay_et;
endmodule

// File: rtl/fec_sat_counter.sv
module fec_sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] value
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != {CNT_W{1'b1}})) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign value = cnt_q;
endmodule

// File: rtl/fec_csr.sv
module fec_csr
    import fec_csr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CODE_W = 4,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_cyc,
    input  logic              wb_stb,
    input  logic              wb_we,
    input  logic [ADDR_W-1:0] wb_adr,
    input  logic [31:0]       wb_dat_w,
    output logic              wb_ack,
    output logic [31:0]       wb_dat_r,
    input  logic [NUM_EVT-1:0] evt_pulse,
    output logic              enc_en,
    output logic              dec_en,
    output logic [CODE_W-1:0] code_type,
    output logic [15:0]       fec_ethtype,
    output logic [15:0]       pay_ethtype
);
    localparam int IDX_W = ADDR_W - 2;

    bus_state_t bus_d, bus_q;
    logic [IDX_W-1:0] word_idx;
    logic             access, wr_access;
    logic [31:0]      rd_word;
    logic [CNT_W-1:0] cnt_val [NUM_EVT];

    assign word_idx  = wb_adr[ADDR_W-1:2];
    assign access    = wb_cyc && wb_stb && !bus_q.ack;
    assign wr_access = access && wb_we;

    fec_cfg_regs #(.CODE_W(CODE_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_enable  (wr_access && (word_idx == IDX_W'(IDX_ENABLE))),
        .wr_code    (wr_access && (word_idx == IDX_W'(IDX_CODE))),
        .wr_fec_et  (wr_access && (word_idx == IDX_W'(IDX_FEC_ET))),
        .wr_pay_et  (wr_access && (word_idx == IDX_W'(IDX_PAY_ET))),
        .wr_data    (wb_dat_w[15:0]),
        .enc_en     (enc_en),
        .dec_en     (dec_en),
        .code_type  (code_type),
        .fec_ethtype(fec_ethtype),
        .pay_ethtype(pay_ethtype)
    );

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_cnt
        fec_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (evt_pulse[g]),
            .value(cnt_val[g])
        );
    end

    always_comb begin
        rd_word = '0;
        case (word_idx)
            IDX_W'(IDX_ENABLE): rd_word = {30'd0, dec_en, enc_en};
            IDX_W'(IDX_CODE):   rd_word = 32'(code_type);
            IDX_W'(IDX_FEC_ET): rd_word = {16'd0, fec_ethtype};
            IDX_W'(IDX_PAY_ET): rd_word = {16'd0, pay_ethtype};
            default:            rd_word = '0;
        endcase
        for (int i = 0; i < NUM_EVT; i++) begin
            if (word_idx == IDX_W'(IDX_CNT_BASE + i)) rd_word = 32'(cnt_val[i]);
        end
    end

    always_comb begin
        bus_d       = bus_q;
        bus_d.ack   = access;
        bus_d.rdata = (access && !wb_we) ? rd_word : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    assign wb_ack   = bus_q.ack;
    assign wb_dat_r = bus_q.rdata;
endmodule

// File: rtl/fec_csr_chk.sv
module fec_csr_chk
    import fec_csr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wb_cyc,
    input logic              wb_stb,
    input logic              wb_we,
    input logic [ADDR_W-1:0] wb_adr,
    input logic              wb_ack,
    input logic [31:0]       wb_dat_r,
    input logic              enc_en,
    input logic              dec_en,
    input logic [CODE_W-1:0] code_type,
    input logic [15:0]       fec_ethtype,
    input logic [15:0]       pay_ethtype
);
    logic [CODE_W+33:0] cfg_vec;
    logic [ADDR_W-3:0]  widx;
    assign cfg_vec = {enc_en, dec_en, code_type, fec_ethtype, pay_ethtype};
    assign widx    = wb_adr[ADDR_W-1:2];

    AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc && wb_stb && !wb_ack) |=> wb_ack); // R5
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |=> !wb_ack); // R5
    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_ack |-> (wb_dat_r == 32'd0)); // R5
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc && wb_stb && !wb_ack && !wb_we && (int'(widx) > IDX_LAST))
        |=> (wb_dat_r == 32'd0)); // R10
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_cyc && wb_stb && wb_we && !wb_ack) |=> $stable(cfg_vec)); // R11
    AST_RESET_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!enc_en && !dec_en && code_type == '0 &&
                           fec_ethtype == FEC_ET_RST && pay_ethtype == PAY_ET_RST)); // R1
endmodule

bind fec_csr fec_csr_chk #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wb_cyc     (wb_cyc),
    .wb_stb     (wb_stb),
    .wb_we      (wb_we),
    .wb_adr     (wb_adr),
    .wb_ack     (wb_ack),
    .wb_dat_r   (wb_dat_r),
    .enc_en     (enc_en),
    .dec_en     (dec_en),
    .code_type  (code_type),
    .fec_ethtype(fec_ethtype),
    .pay_ethtype(pay_ethtype)
);

// File: tb/fec_csr_test.sv
module fec_csr_test;
    import fec_csr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 6;
    localparam int CODE_W = 4;
    localparam int CNT_W  = 8;
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
    logic [ADDR_W-1:0] wb_adr = '0;
    logic [31:0] wb_dat_w = '0;
    logic wb_ack;
    logic [31:0] wb_dat_r;
    logic [NUM_EVT-1:0] evt_pulse = '0;
    logic enc_en, dec_en;
    logic [CODE_W-1:0] code_type;
    logic [15:0] fec_ethtype, pay_ethtype;

    int n_checks = 0;
    int n_fail = 0;
    logic [CNT_W-1:0] exp_cnt [NUM_EVT];
    logic [31:0] exp_reg [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    fec_csr #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
        .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .wb_ack(wb_ack), .wb_dat_r(wb_dat_r),
        .evt_pulse(evt_pulse), .enc_en(enc_en), .dec_en(dec_en), .code_type(code_type),
        .fec_ethtype(fec_ethtype), .pay_ethtype(pay_ethtype)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] stored(input int idx, input logic [31:0] d);
        case (idx)
            IDX_ENABLE: return {30'd0, d[1:0]};
            IDX_CODE:   return 32'(d[CODE_W-1:0]);
            default:    return {16'd0, d[15:0]};
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
        return (c == CMAX) ? CMAX : c + 1'b1;
    endfunction

    task automatic bus(input bit we, input int word, input logic [31:0] wdat, output logic [31:0] rdat);
        @(negedge clk);
        check(wb_ack == 1'b0, "R5 ack low before access", 32'(wb_ack), 0);
        wb_cyc = 1; wb_stb = 1; wb_we = we;
        wb_adr = ADDR_W'(word * 4); wb_dat_w = wdat;
        @(posedge clk); #1;
        check(wb_ack == 1'b1, "R5 ack one cycle after strobe", 32'(wb_ack), 1);
        rdat = wb_dat_r;
        @(negedge clk);
        wb_cyc = 0; wb_stb = 0; wb_we = 0;
        @(posedge clk); #1;
        check(wb_ack == 1'b0, "R5 ack single cycle", 32'(wb_ack), 0);
    endtask

    task automatic wr(input int word, input logic [31:0] d);
        logic [31:0] dummy;
        bus(1'b1, word, d, dummy);
    endtask

    task automatic rd_check(input int word, input logic [31:0] exp, input string req);
        logic [31:0] r;
        bus(1'b0, word, 32'd0, r);
        check(r == exp, req, r, exp);
    endtask

    task automatic check_outputs(input string req);
        check(enc_en == exp_reg[IDX_ENABLE][0] && dec_en == exp_reg[IDX_ENABLE][1],
              req, {30'd0, dec_en, enc_en}, exp_reg[IDX_ENABLE]);
        check(32'(code_type) == exp_reg[IDX_CODE], req, 32'(code_type), exp_reg[IDX_CODE]);
        check({16'd0, fec_ethtype} == exp_reg[IDX_FEC_ET], req, {16'd0, fec_ethtype}, exp_reg[IDX_FEC_ET]);
        check({16'd0, pay_ethtype} == exp_reg[IDX_PAY_ET], req, {16'd0, pay_ethtype}, exp_reg[IDX_PAY_ET]);
    endtask

    task automatic check_counters(input string req);
        for (int i = 0; i < NUM_EVT; i++) rd_check(IDX_CNT_BASE + i, 32'(exp_cnt[i]), req);
    endtask

    task automatic pulses(input int cycles, input logic [NUM_EVT-1:0] mask, input bit rnd);
        for (int c = 0; c < cycles; c++) begin
            logic [NUM_EVT-1:0] v;
            @(negedge clk);
            v = rnd ? (NUM_EVT'($urandom) & mask) : mask;
            evt_pulse = v;
            for (int i = 0; i < NUM_EVT; i++) if (v[i]) exp_cnt[i] = bump(exp_cnt[i]);
        end
        @(negedge clk);
        evt_pulse = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NUM_EVT; i++) exp_cnt[i] = '0;
        exp_reg[IDX_ENABLE] = 0; exp_reg[IDX_CODE] = 0;
        exp_reg[IDX_FEC_ET] = 32'h0000BABE; exp_reg[IDX_PAY_ET] = 32'h00000800;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1 reset state
        check_outputs("R1 reset outputs");
        for (int i = 0; i < 4; i++) rd_check(i, exp_reg[i], "R1 reset register");
        check_counters("R1 reset counters");

        // R2 all enable encodings
        for (int v = 0; v < 4; v++) begin
            wr(IDX_ENABLE, 32'hFFFF_FFFC | 32'(v));
            exp_reg[IDX_ENABLE] = 32'(v);
            check(enc_en == v[0] && dec_en == v[1], "R2 enable outputs", {30'd0, dec_en, enc_en}, 32'(v));
            rd_check(IDX_ENABLE, 32'(v), "R2 enable readback");
        end

        // R3 R4 random configuration writes with stray upper bits
        for (int k = 0; k < 12; k++) begin
            int idx;
            logic [31:0] d;
            idx = 1 + ($urandom % 3);
            d = $urandom;
            wr(idx, d);
            exp_reg[idx] = stored(idx, d);
            rd_check(idx, exp_reg[idx], idx == IDX_CODE ? "R3 code type" : "R4 ethertype");
            check_outputs(idx == IDX_CODE ? "R3 code output" : "R4 ethertype output");
        end

        // R10 unmapped offsets
        for (int w = IDX_LAST + 1; w < (1 << (ADDR_W - 2)); w++) begin
            wr(w, 32'hFFFF_FFFF);
            rd_check(w, 32'd0, "R10 unmapped read zero");
        end
        check_outputs("R10 unmapped write no effect");
        check_counters("R10 unmapped write counters");

        // R6 one counter at a time, R7 random simultaneous pulses
        for (int i = 0; i < NUM_EVT; i++) begin
            pulses(i + 1, NUM_EVT'(1) << i, 1'b0);
            check_counters("R6 counter mapping");
        end
        for (int r = 0; r < 6; r++) begin
            pulses(1 + ($urandom % 20), '1, 1'b1);
            check_counters("R7 simultaneous pulses");
            check_outputs("R11 config unchanged by pulses");
        end
        pulses(12, '1, 1'b0);
        check_counters("R7 back-to-back all bits");

        // R9 counter writes ignored
        for (int i = 0; i < NUM_EVT; i++) wr(IDX_CNT_BASE + i, $urandom);
        check_counters("R9 counter write ignored");
        check_outputs("R11 counter write leaves config");

        // R8 saturation on decode-failure counter
        pulses(300, NUM_EVT'(1) << 3, 1'b0);
        check(exp_cnt[3] == CMAX, "R8 model saturated", 32'(exp_cnt[3]), 32'(CMAX));
        rd_check(IDX_CNT_BASE + 3, 32'(CMAX), "R8 saturation holds");
        pulses(5, '1, 1'b0);
        check_counters("R8 R7 after saturation");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule